// File: doc/BRIEF.md
# Selectable CRC-16 word engine

This block folds a stream of 16-bit words into a 16-bit cyclic redundancy check at one word per clock. The generator polynomial is always x^16 + x^12 + x^5 + 1. Two variants are offered, and they differ only in the value loaded into the register when a frame opens. The default variant loads all ones and is the CCITT-FALSE form. The alternative loads all zeros and is the XMODEM form. Neither variant reflects its data or its result, and neither applies a final XOR.

A frame opens with a start-of-frame pulse, and a word may be presented in that same cycle. The variant select is read only in that cycle. A new setting from software therefore applies to the next frame and never to the frame already running. The engine serves both directions of a command link. In generate mode the caller reads the running result after the last word and appends it. In check mode the caller presents the received CRC word with a check strobe. The engine then closes the frame and reports the comparison result. A per-word byte-lane mode folds only the low eight bits of a word, so that byte-granular reference strings can be checked.

Control is a three-state machine. IDLE is the state after reset. RUN is a frame in progress. CLOSED follows a check. The transitions are:
- IDLE to RUN, on start of frame.
- RUN to RUN, on start of frame (restart).
- RUN to CLOSED, on a check strobe.
- CLOSED to RUN, on start of frame.

Top module: `crc16w_engine`

## Requirements
- R1: After reset, crc_o is 0xFFFF and frame_o, chk_done_o and mism_o are all 0.
- R2: Inside a frame, each accepted word updates the register with polynomial 0x1021, taking word bits from MSB (bit 15) to bit 0, one whole word per clock. The new value appears on crc_o in the cycle after the word is presented.
- R3: On sof_i, the register is preset to 0xFFFF when alg_sel_i is 0 (CCITT-FALSE) or to 0x0000 when alg_sel_i is 1 (XMODEM). A word presented with sof_i is folded onto that preset.
- R4: alg_sel_i is read only in a cycle with sof_i. Changing it during a frame does not alter that frame's result.
- R5: When byte_mode_i is 1, only word_i[7:0] is folded, MSB first (bit 7 first). The bytes of ASCII "123456789" give 0x29B1 with alg_sel_i=0 and 0x31C3 with alg_sel_i=1.
- R6: Outside a frame (IDLE or CLOSED), word_vld_i has no effect on crc_o.
- R7: chk_vld_i during RUN compares word_i with crc_o. In the next cycle, chk_done_o is 1 for exactly one cycle and mism_o is 1 for that cycle only if the two differed. The frame closes and crc_o holds.
- R8: chk_vld_i outside a frame produces no chk_done_o or mism_o pulse.
- R9: When chk_vld_i and word_vld_i are both 1 in RUN, the check wins and the word is not folded.
- R10: frame_o is 1 from the cycle after sof_i until the cycle after an accepted check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of frame: preset the register and open a frame |
| alg_sel_i | input | 1 | Variant select, 0 = CCITT-FALSE, 1 = XMODEM; read only with sof_i |
| word_vld_i | input | 1 | word_i carries a data word to fold |
| byte_mode_i | input | 1 | Fold only word_i[7:0] for this word |
| chk_vld_i | input | 1 | word_i carries a received CRC to compare |
| word_i | input | 16 | Data word or received CRC |
| crc_o | output | 16 | Running CRC register |
| frame_o | output | 1 | A frame is in progress |
| chk_done_o | output | 1 | One-cycle pulse: a comparison was made |
| mism_o | output | 1 | One-cycle pulse: the compared CRC differed |

## Verification
The hardest case to reach is a change of variant inside a running frame. Because both variants share one polynomial, a wrong design can still produce a correct-looking value unless the preset actually matters. The bench flips alg_sel_i partway through a frame that was opened under the other setting. It then compares the result against a bench model that starts from the preset sampled at frame start. The bench also runs an exhaustive single-byte sweep under both variants. It checks the interaction of checks with data strobes by driving both strobes in the same cycle and by strobing outside a frame.

// File: rtl/crc16w_pkg.sv
package crc16w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_CLOSED = 2'd2
    } crc16w_state_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_FOLD = 2'd2
    } crc16w_sel_e;

endpackage

// File: rtl/crc16w_step.sv
module crc16w_step #(
    parameter int            CRC_W = 16,
    parameter logic [15:0]   POLY  = 16'h1021,
    parameter int            DW    = 16
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [DW-1:0]    din,
    output logic [CRC_W-1:0] crc_out
);
    // Unrolled MSB-first serial update
    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in;
        for (int i = DW - 1; i >= 0; i--) begin
            if (acc[CRC_W-1] ^ din[i]) begin
                acc = {acc[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
            end else begin
                acc = {acc[CRC_W-2:0], 1'b0};
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/crc16w_fsm.sv
module crc16w_fsm
    import crc16w_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof_i,
    input  logic        word_vld_i,
    input  logic        chk_vld_i,
    input  logic        crc_eq_i,
    output crc16w_sel_e sel_o,
    output logic        frame_o,
    output logic        done_o,
    output logic        mism_o
);
    crc16w_state_e state_q, state_d;
    logic          chk_take;

    assign chk_take = (state_q == ST_RUN) && chk_vld_i && !sof_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sof_i)          state_d = ST_RUN;
                else if (chk_vld_i) state_d = ST_CLOSED;
            end
            ST_CLOSED: begin
                if (sof_i) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register select
    always_comb begin
        if (sof_i)                                       sel_o = SEL_LOAD;
        else if (state_q == ST_RUN && !chk_vld_i && word_vld_i) sel_o = SEL_FOLD;
        else                                             sel_o = SEL_HOLD;
    end

    assign frame_o = (state_q == ST_RUN);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            mism_o <= 1'b0;
        end else begin
            done_o <= chk_take;
            mism_o <= chk_take && !crc_eq_i;
        end
    end
endmodule

// File: rtl/crc16w_engine.sv
module crc16w_engine
    import crc16w_pkg::*;
#(
    parameter int          CRC_W    = 16,
    parameter int          DATA_W   = 16,
    parameter int          LANE_W   = 8,
    parameter logic [15:0] POLY     = 16'h1021,
    parameter logic [15:0] PRESET_A = 16'hFFFF,
    parameter logic [15:0] PRESET_B = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              alg_sel_i,
    input  logic              word_vld_i,
    input  logic              byte_mode_i,
    input  logic              chk_vld_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              frame_o,
    output logic              chk_done_o,
    output logic              mism_o
);
    localparam logic [CRC_W-1:0] P_A = PRESET_A[CRC_W-1:0];
    localparam logic [CRC_W-1:0] P_B = PRESET_B[CRC_W-1:0];

    logic [CRC_W-1:0] crc_q, crc_d, preset, base, fold_w, fold_b, folded;
    crc16w_sel_e      sel;
    logic             crc_eq;

    assign preset = alg_sel_i ? P_B : P_A;
    assign base   = (sel == SEL_LOAD) ? preset : crc_q;
    assign crc_eq = (word_i[CRC_W-1:0] == crc_q);

    crc16w_step #(.CRC_W(CRC_W), .POLY(POLY), .DW(DATA_W)) u_step_word (
        .crc_in (base),
        .din    (word_i),
        .crc_out(fold_w)
    );

    crc16w_step #(.CRC_W(CRC_W), .POLY(POLY), .DW(LANE_W)) u_step_lane (
        .crc_in (base),
        .din    (word_i[LANE_W-1:0]),
        .crc_out(fold_b)
    );

    assign folded = byte_mode_i ? fold_b : fold_w;

    always_comb begin
        unique case (sel)
            SEL_LOAD: crc_d = word_vld_i ? folded : preset;
            SEL_FOLD: crc_d = folded;
            default:  crc_d = crc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= P_A;
        else        crc_q <= crc_d;
    end

    crc16w_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_i     (sof_i),
        .word_vld_i(word_vld_i),
        .chk_vld_i (chk_vld_i),
        .crc_eq_i  (crc_eq),
        .sel_o     (sel),
        .frame_o   (frame_o),
        .done_o    (chk_done_o),
        .mism_o    (mism_o)
    );

    assign crc_o = crc_q;
endmodule

// File: rtl/crc16w_engine_chk.sv
module crc16w_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sof_i,
    input logic        alg_sel_i,
    input logic        word_vld_i,
    input logic        chk_vld_i,
    input logic [15:0] crc_o,
    input logic        frame_o,
    input logic        chk_done_o,
    input logic        mism_o
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done_o |=> !chk_done_o); // R7
    AST_MISM_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mism_o |-> chk_done_o); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_o && !sof_i) |=> $stable(crc_o)); // R6
    AST_SOF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> frame_o); // R10
    AST_NO_CHK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_o && chk_vld_i) |=> !chk_done_o); // R8
    AST_PRESET_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !word_vld_i && !alg_sel_i) |=> (crc_o == 16'hFFFF)); // R3
    AST_PRESET_XMODEM: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !word_vld_i && alg_sel_i) |=> (crc_o == 16'h0000)); // R3
    AST_CHK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && chk_vld_i && !sof_i) |=> ($stable(crc_o) && !frame_o)); // R9
endmodule

bind crc16w_engine crc16w_engine_chk chk_i (.*);

// File: tb/crc16w_engine_tb_top.sv
`timescale 1ns/1ps
module crc16w_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0, alg_sel_i = 1'b0, word_vld_i = 1'b0;
    logic        byte_mode_i = 1'b0, chk_vld_i = 1'b0;
    logic [15:0] word_i = '0;
    logic [15:0] crc_o;
    logic        frame_o, chk_done_o, mism_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] wbuf [0:31];
    bit          mbuf [0:31];

    always #4 clk = ~clk;

    crc16w_engine dut_i (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .alg_sel_i(alg_sel_i),
        .word_vld_i(word_vld_i), .byte_mode_i(byte_mode_i), .chk_vld_i(chk_vld_i),
        .word_i(word_i), .crc_o(crc_o), .frame_o(frame_o),
        .chk_done_o(chk_done_o), .mism_o(mism_o)
    );

    function automatic logic [15:0] mdl(input logic [15:0] c, input logic [15:0] w, input bit bm);
        int nb;
        nb = bm ? 8 : 16;
        for (int i = nb - 1; i >= 0; i--) begin
            if (c[15] ^ w[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        sof_i = 0; word_vld_i = 0; chk_vld_i = 0; byte_mode_i = 0;
    endtask

    // Send n words from wbuf/mbuf as one frame; returns model CRC
    task automatic send(input bit alg, input int n, output logic [15:0] exp);
        exp = alg ? 16'h0000 : 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            sof_i = (i == 0); alg_sel_i = alg; word_vld_i = 1;
            word_i = wbuf[i]; byte_mode_i = mbuf[i];
            exp = mdl(exp, wbuf[i], mbuf[i]);
            step();
        end
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp, held, lfsr;
        string s;
        s = "123456789";
        repeat (3) step();
        rst_n = 1;
        step();
        // R1
        chk("R1 crc", crc_o, 16'hFFFF);
        chk("R1 frame", {15'd0, frame_o}, 16'd0);
        chk("R1 done/mism", {14'd0, chk_done_o, mism_o}, 16'd0);

        // R5 reference string, byte lane
        for (int a = 0; a < 2; a++) begin
            for (int i = 0; i < 9; i++) begin wbuf[i] = {8'h00, s[i]}; mbuf[i] = 1; end
            send(a[0], 9, exp);
            chk("R5 string", crc_o, a ? 16'h31C3 : 16'h29B1);
            chk("R5 model", crc_o, exp);
        end
        // R5 packed words plus trailing byte
        for (int a = 0; a < 2; a++) begin
            for (int i = 0; i < 4; i++) begin wbuf[i] = {s[2*i], s[2*i+1]}; mbuf[i] = 0; end
            wbuf[4] = {8'hA5, s[8]}; mbuf[4] = 1;
            send(a[0], 5, exp);
            chk("R5 packed", crc_o, a ? 16'h31C3 : 16'h29B1);
        end

        // R2/R3/R10 sweep of lengths and variants
        lfsr = 16'hACE1;
        for (int a = 0; a < 2; a++) begin
            for (int n = 1; n <= 16; n++) begin
                for (int i = 0; i < n; i++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    wbuf[i] = lfsr; mbuf[i] = 0;
                end
                send(a[0], n, exp);
                chk("R2 word sweep", crc_o, exp);
                chk("R10 frame open", {15'd0, frame_o}, 16'd1);
            end
        end

        // R5/R3 exhaustive single byte
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 256; b++) begin
                wbuf[0] = {8'h5A, b[7:0]}; mbuf[0] = 1;
                send(a[0], 1, exp);
                chk("R5 byte sweep", crc_o, exp);
            end
        end

        // R3 preset without word
        for (int a = 0; a < 2; a++) begin
            sof_i = 1; alg_sel_i = a[0]; step(); quiet();
            chk("R3 preset", crc_o, a ? 16'h0000 : 16'hFFFF);
        end

        // R4 mid-frame variant change
        for (int a = 0; a < 2; a++) begin
            exp = a ? 16'h0000 : 16'hFFFF;
            sof_i = 1; alg_sel_i = a[0]; word_vld_i = 1; word_i = 16'h1234;
            exp = mdl(exp, 16'h1234, 0); step();
            sof_i = 0; alg_sel_i = ~a[0];
            for (int i = 0; i < 4; i++) begin
                word_i = 16'h0F0F + 16'(i); exp = mdl(exp, word_i, 0); step();
            end
            quiet();
            chk("R4 variant held", crc_o, exp);
        end

        // R7 check with correct CRC
        wbuf[0] = 16'hBEEF; wbuf[1] = 16'h0001; mbuf[0] = 0; mbuf[1] = 0;
        send(0, 2, exp);
        chk_vld_i = 1; word_i = exp; step(); quiet();
        chk("R7 done good", {15'd0, chk_done_o}, 16'd1);
        chk("R7 mism good", {15'd0, mism_o}, 16'd0);
        chk("R10 frame closed", {15'd0, frame_o}, 16'd0);
        chk("R7 crc hold", crc_o, exp);
        step();
        chk("R7 done pulse", {15'd0, chk_done_o}, 16'd0);

        // R7 check with wrong CRC
        send(1, 2, exp);
        chk_vld_i = 1; word_i = exp ^ 16'h0100; step(); quiet();
        chk("R7 done bad", {15'd0, chk_done_o}, 16'd1);
        chk("R7 mism bad", {15'd0, mism_o}, 16'd1);
        step();
        chk("R7 mism pulse", {15'd0, mism_o}, 16'd0);

        // R6 words after close are ignored
        held = crc_o;
        for (int i = 0; i < 4; i++) begin word_vld_i = 1; word_i = 16'h7700 + 16'(i); step(); end
        quiet();
        chk("R6 closed ignore", crc_o, held);

        // R8 check outside frame
        chk_vld_i = 1; word_i = 16'h1111; step(); quiet();
        chk("R8 no done", {15'd0, chk_done_o}, 16'd0);
        chk("R8 no mism", {15'd0, mism_o}, 16'd0);

        // R6 in IDLE after reset
        rst_n = 0; step(); rst_n = 1; step();
        word_vld_i = 1; word_i = 16'hFACE; step(); quiet();
        chk("R6 idle ignore", crc_o, 16'hFFFF);

        // R9 check wins over word
        wbuf[0] = 16'h4242; mbuf[0] = 0;
        send(0, 1, exp);
        chk_vld_i = 1; word_vld_i = 1; word_i = 16'h9999; step(); quiet();
        chk("R9 no fold", crc_o, exp);
        chk("R9 done", {15'd0, chk_done_o}, 16'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule